// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Ready Signalling

This block is the digital control core of a multichannel converter. After a mode write that selects continuous conversion, it runs the enabled channels one after another. Each channel's conversion takes as many clock cycles as that channel's conversion-time field gives. A result stub stands in for the analog modulator. Each result it produces is placed in the channel's data register together with a status byte, and the channel's ready bit is raised.

A single active-low ready pin summarises the ready bits in one of two ways. In the first it goes low as soon as any channel holds unread data. In the second it goes low only once every enabled channel holds unread data. If an unread result is overwritten, the pin is forced high for a fixed hold window. If a result arrives while its channel is being read, that result is dropped so the read is not corrupted. The serial shifter and the analog front end sit outside this block.

Top module: `convrdy_ctrl`

## Requirements
- R1: A mode write (`mode_wr` high at a clock edge) clears every ready bit, cancels any overwrite hold and leaves `rdy_n` high after that edge. With `mode_cont`=1 it restarts conversion on channel `mode_ch`, with the result sequence number set to 0.
- R2: A conversion lasts exactly T clock edges, where T is the channel's 8-bit field `ctime[8*c +: 8]` (0 acts as 1). The first result lands T edges after the mode-write edge, and one full pass takes the sum of the enabled channels' times.
- R3: After each completion, conversion moves to the next enabled channel in ascending index order. After the highest enabled channel it wraps to the lowest, and a single enabled channel repeats on itself.
- R4: While `ch_en` is all zero, no conversion time elapses and no register changes.
- R5: A stored result sets the channel's ready bit. The data register gets `{channel index (2 bits), sequence number (14 bits)}`, where the sequence number counts completions since the mode write. Status bits [1:0] get the channel index and bit 7 is 0.
- R6: A cycle with `rd_busy[c]` high clears ready bit c at that edge.
- R7: With `rdy_all`=0 and no hold active, `rdy_n` is low exactly when any ready bit is set.
- R8: With `rdy_all`=1 and no hold active, `rdy_n` is low only when every enabled channel's ready bit is set.
- R9: A result stored while the channel's ready bit is still set is an overwrite. The new data is stored, status bit 7 is set, and `rdy_n` is forced high for HOLD (163) edges, restarting on each new overwrite. During that window the overwritten channel's ready bit reads 0, and afterwards it reads 1 again.
- R10: A completion on a channel whose `rd_busy` is high leaves that channel's data register and ready bit unchanged. The result is lost, but the sequence number still advances.
- R11: A mode write with `mode_cont`=0 stops the sequencer, and no further results are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode-write strobe |
| mode_cont | input | 1 | 1 = continuous conversion, 0 = stop |
| mode_ch | input | 2 | Start channel for the mode write |
| ch_en | input | 4 | Channel-enable mask |
| rdy_all | input | 1 | Ready-pin function: 0 = any channel, 1 = all enabled channels |
| ctime | input | 32 | Per-channel conversion times, 8 bits per channel |
| rd_busy | input | 4 | Per-channel data-read-in-progress level |
| rdy_n | output | 1 | Active-low ready pin |
| rdy_bits | output | 4 | Visible per-channel ready bits |
| data_q | output | 64 | Channel data registers, 16 bits per channel |
| stat_q | output | 32 | Channel status registers, 8 bits per channel |

## Verification
The bench drives mixed conversion times with one channel disabled and checks the exact edge where each ready bit rises. A design that counts one cycle too many, or visits a disabled channel, puts results in the wrong order or at the wrong time. An unread channel is then overwritten while another channel still holds data. The pin must stay high through the whole hold window and fall on the first edge after it, with the hidden bit coming back. A sequencer that forgot the hold, or never cleared it, fails here. A long read across a completion must leave the old data in place while the sequence number moves on. A design that let the write through, or stalled the count, shows it in the next stored value.

// File: rtl/convrdy_pkg.sv
package convrdy_pkg;
  // Conversion length in cycles; a zero field still takes one cycle.
  function automatic logic [31:0] conv_len(logic [31:0] t);
    return (t == 32'd0) ? 32'd1 : t;
  endfunction

  // Next enabled channel after cur, ascending with wrap; cur if none.
  function automatic logic [31:0] next_ch(logic [31:0] cur, logic [31:0] en,
                                          int unsigned n);
    logic [31:0] r;
    logic        f;
    int unsigned idx;
    r = cur;
    f = 1'b0;
    for (int unsigned k = 1; k <= 32; k++) begin
      if (!f && k <= n) begin
        idx = (cur + k) % n;
        if (en[idx]) begin
          r = idx;
          f = 1'b1;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/cr_seq.sv
module cr_seq #(
  parameter int NCH = 4,
  parameter int TW  = 8,
  parameter int CW  = 2,
  parameter int SQW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_cont,
  input  logic [CW-1:0]     mode_ch,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH*TW-1:0] ctime,
  output logic              done,
  output logic [CW-1:0]     done_ch,
  output logic [SQW-1:0]    seq
);
  import convrdy_pkg::*;

  logic          run_q;
  logic [CW-1:0] cur_q;
  logic [TW-1:0] tcnt_q;
  logic [SQW-1:0] seq_q;
  logic [31:0]   tlen;
  logic          active;

  assign tlen    = conv_len(32'(ctime[cur_q*TW +: TW]));
  assign active  = run_q && (|ch_en) && !mode_wr;
  assign done    = active && (tcnt_q == TW'(tlen - 32'd1));
  assign done_ch = cur_q;
  assign seq     = seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cur_q  <= '0;
      tcnt_q <= '0;
      seq_q  <= '0;
    end else if (mode_wr) begin
      run_q  <= mode_cont;
      cur_q  <= mode_ch;
      tcnt_q <= '0;
      seq_q  <= '0;
    end else if (active) begin
      if (done) begin
        tcnt_q <= '0;
        cur_q  <= CW'(next_ch(32'(cur_q), 32'(ch_en), NCH));
        seq_q  <= seq_q + 1'b1;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cr_store.sv
module cr_store #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int CW  = 2,
  parameter int SW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              done,
  input  logic [CW-1:0]     done_ch,
  input  logic [DW-1:0]     result,
  input  logic [NCH-1:0]    rd_busy,
  output logic [NCH*DW-1:0] data_q,
  output logic [NCH*SW-1:0] stat_q,
  output logic [NCH-1:0]    rdy_q,
  output logic [NCH-1:0]    store_vec,
  output logic [NCH-1:0]    blk_vec,
  output logic [NCH-1:0]    ovw_vec
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic          hit;
    logic [SW-1:0] stat_nx;

    assign hit          = done && (done_ch == CW'(i));
    assign store_vec[i] = hit && !rd_busy[i];
    assign blk_vec[i]   = hit && rd_busy[i];
    assign ovw_vec[i]   = store_vec[i] && rdy_q[i];

    always_comb begin
      stat_nx          = '0;
      stat_nx[SW-1]    = ovw_vec[i];
      stat_nx[CW-1:0]  = CW'(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i*DW +: DW] <= '0;
        stat_q[i*SW +: SW] <= '0;
        rdy_q[i]           <= 1'b0;
      end else begin
        if (store_vec[i]) begin
          data_q[i*DW +: DW] <= result;
          stat_q[i*SW +: SW] <= stat_nx;
        end
        if (clr_all || rd_busy[i]) rdy_q[i] <= 1'b0;
        else if (store_vec[i])     rdy_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cr_pin.sv
module cr_pin #(
  parameter int NCH  = 4,
  parameter int HOLD = 163
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_all,
  input  logic [NCH-1:0] ovw_vec,
  input  logic [NCH-1:0] rdy_q,
  input  logic [NCH-1:0] ch_en,
  input  logic           rdy_all,
  output logic [NCH-1:0] rdy_vis,
  output logic           hold_on,
  output logic           rdy_n
);
  localparam int HW = $clog2(HOLD + 1);

  logic [HW-1:0]  hcnt_q;
  logic [NCH-1:0] omask_q;
  logic           any_rdy, all_rdy;

  assign hold_on = (hcnt_q != '0);
  assign rdy_vis = rdy_q & ~omask_q;
  assign any_rdy = |rdy_vis;
  assign all_rdy = (|ch_en) && ((rdy_vis & ch_en) == ch_en);
  assign rdy_n   = hold_on || !(rdy_all ? all_rdy : any_rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      omask_q <= '0;
    end else if (clr_all) begin
      hcnt_q  <= '0;
      omask_q <= '0;
    end else if (|ovw_vec) begin
      hcnt_q  <= HW'(HOLD);
      omask_q <= omask_q | ovw_vec;
    end else if (hold_on) begin
      hcnt_q <= hcnt_q - 1'b1;
      if (hcnt_q == HW'(1)) omask_q <= '0;
    end
  end
endmodule

// File: rtl/convrdy_ctrl.sv
module convrdy_ctrl #(
  parameter int NCH  = 4,
  parameter int DW   = 16,
  parameter int TW   = 8,
  parameter int SW   = 8,
  parameter int HOLD = 163,
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SQW = DW - CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic              mode_cont,
  input  logic [CW-1:0]     mode_ch,
  input  logic [NCH-1:0]    ch_en,
  input  logic              rdy_all,
  input  logic [NCH*TW-1:0] ctime,
  input  logic [NCH-1:0]    rd_busy,
  output logic              rdy_n,
  output logic [NCH-1:0]    rdy_bits,
  output logic [NCH*DW-1:0] data_q,
  output logic [NCH*SW-1:0] stat_q
);
  // Stand-in for the modulator: channel index over completion number.
  function automatic logic [DW-1:0] stub_result(logic [CW-1:0] c, logic [SQW-1:0] s);
    return {c, s};
  endfunction

  logic           done;
  logic [CW-1:0]  done_ch;
  logic [SQW-1:0] seq;
  logic [DW-1:0]  result;
  logic [NCH-1:0] rdy_q, store_vec, blk_vec, ovw_vec;
  logic           hold_on;

  assign result = stub_result(done_ch, seq);

  cr_seq #(.NCH(NCH), .TW(TW), .CW(CW), .SQW(SQW)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_cont(mode_cont),
    .mode_ch(mode_ch), .ch_en(ch_en), .ctime(ctime),
    .done(done), .done_ch(done_ch), .seq(seq)
  );

  cr_store #(.NCH(NCH), .DW(DW), .CW(CW), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_all(mode_wr), .done(done), .done_ch(done_ch),
    .result(result), .rd_busy(rd_busy), .data_q(data_q), .stat_q(stat_q),
    .rdy_q(rdy_q), .store_vec(store_vec), .blk_vec(blk_vec), .ovw_vec(ovw_vec)
  );

  cr_pin #(.NCH(NCH), .HOLD(HOLD)) u_pin (
    .clk(clk), .rst_n(rst_n), .clr_all(mode_wr), .ovw_vec(ovw_vec), .rdy_q(rdy_q),
    .ch_en(ch_en), .rdy_all(rdy_all), .rdy_vis(rdy_bits), .hold_on(hold_on),
    .rdy_n(rdy_n)
  );
endmodule

// File: rtl/cr_chk.sv
module cr_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wr,
  input logic              rdy_all,
  input logic [NCH-1:0]    rd_busy,
  input logic              rdy_n,
  input logic [NCH-1:0]    rdy_bits,
  input logic [NCH*DW-1:0] data_q,
  input logic [NCH-1:0]    blk_vec,
  input logic [NCH-1:0]    ovw_vec,
  input logic [NCH-1:0]    store_vec,
  input logic              hold_on
);
  // R1
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (rdy_bits == '0) && rdy_n);
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_busy) |=> ((rdy_bits & $past(rd_busy)) == '0));
  // R9
  ovr_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovw_vec) |=> rdy_n);
  // R10
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|blk_vec) |=> $stable(data_q));
  // R7
  any_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_all && !hold_on && (|rdy_bits)) |-> !rdy_n);
  // R5
  one_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_vec | blk_vec));
endmodule

bind convrdy_ctrl cr_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .rdy_all(rdy_all),
  .rd_busy(rd_busy), .rdy_n(rdy_n), .rdy_bits(rdy_bits), .data_q(data_q),
  .blk_vec(blk_vec), .ovw_vec(ovw_vec), .store_vec(store_vec), .hold_on(hold_on)
);

// File: tb/sim_convrdy_ctrl.sv
module sim_convrdy_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0, mode_cont = 1'b0, rdy_all = 1'b0;
  logic [1:0]  mode_ch = '0;
  logic [3:0]  ch_en = '0, rd_busy = '0;
  logic [31:0] ctime = {8'd4, 8'd7, 8'd3, 8'd5};
  logic        rdy_n;
  logic [3:0]  rdy_bits;
  logic [63:0] data_q;
  logic [31:0] stat_q;

  int n_chk = 0, n_bad = 0;
  int exp_ch[$];
  int exp_dat[$];
  bit fin = 1'b0;

  always #2.5 clk = ~clk;

  convrdy_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_cont(mode_cont),
    .mode_ch(mode_ch), .ch_en(ch_en), .rdy_all(rdy_all), .ctime(ctime),
    .rd_busy(rd_busy), .rdy_n(rdy_n), .rdy_bits(rdy_bits), .data_q(data_q),
    .stat_q(stat_q)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic adv(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic mode(logic [1:0] ch, logic cont, logic [3:0] en);
    mode_ch = ch; mode_cont = cont; ch_en = en; mode_wr = 1'b1;
    tick();
    mode_wr = 1'b0;
  endtask

  // driver side of the scoreboard: result word is {ch, 14-bit sequence}
  task automatic expect_res(int ch, int sq);
    exp_ch.push_back(ch);
    exp_dat.push_back((ch << 14) | sq);
  endtask

  // monitor: every data-register change must match the next expected item
  initial begin
    logic [63:0] prev;
    prev = '0;
    wait (rst_n);
    forever begin
      tick();
      for (int c = 0; c < 4; c++) begin
        if (data_q[c*16 +: 16] != prev[c*16 +: 16]) begin
          if (exp_ch.size() == 0) begin
            chk(1'b0, "R4/R11 unexpected update", c, -1);
          end else begin
            int ec, ed;
            ec = exp_ch.pop_front();
            ed = exp_dat.pop_front();
            chk(c == ec && data_q[c*16 +: 16] == 16'(ed), "R3/R5 result",
                {c[15:0], data_q[c*16 +: 16]}, {ec[15:0], ed[15:0]});
            chk(stat_q[c*8 +: 2] == 2'(c), "R5 status channel", stat_q[c*8 +: 8], c);
          end
        end
      end
      prev = data_q;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    adv(3);
    chk(rdy_n == 1'b1 && rdy_bits == 4'b0, "R1 reset state", {rdy_n, rdy_bits}, 5'h10);
    rst_n = 1'b1;
    adv(2);

    // Phase A: channels 0,1,3 enabled, start at 1, any-mode
    expect_res(1, 0); expect_res(3, 1); expect_res(0, 2);
    expect_res(1, 3); expect_res(3, 4);
    mode(2'd1, 1'b1, 4'b1011);
    chk(rdy_bits == 4'b0 && rdy_n, "R1 after mode write", rdy_bits, 0);
    adv(2);
    chk(rdy_bits == 4'b0, "R2 not yet complete", rdy_bits, 0);
    adv(1);
    chk(rdy_bits == 4'b0010, "R2 R5 first result at T", rdy_bits, 4'b0010);
    chk(rdy_n == 1'b0, "R7 any ready", rdy_n, 0);
    chk(stat_q[15] == 1'b0, "R5 no overwrite flag", stat_q[15:8], 8'h01);
    rd_busy = 4'b0010;
    adv(1);
    chk(rdy_bits == 4'b0 && rdy_n, "R6 read clears", {rdy_n, rdy_bits}, 5'h10);
    adv(1);
    rd_busy = 4'b0;
    adv(2);
    chk(rdy_bits == 4'b1000, "R3 skip disabled ch2", rdy_bits, 4'b1000);
    adv(5);
    chk(rdy_bits == 4'b1001, "R3 wrap to ch0", rdy_bits, 4'b1001);
    adv(3);
    chk(rdy_bits == 4'b1011, "R2 full pass sum", rdy_bits, 4'b1011);
    rdy_all = 1'b1; #1;
    chk(rdy_n == 1'b0, "R8 all enabled ready", rdy_n, 0);
    rd_busy = 4'b0001;
    adv(1);
    rd_busy = 4'b0; #1;
    chk(rdy_bits == 4'b1010 && rdy_n, "R8 one missing keeps high", {rdy_n, rdy_bits}, 5'h1a);
    rdy_all = 1'b0; #1;
    chk(rdy_n == 1'b0, "R7 any mode low", rdy_n, 0);
    adv(3);
    chk(rdy_bits == 4'b0010, "R9 overwritten bit hidden", rdy_bits, 4'b0010);
    chk(rdy_n == 1'b1, "R9 pin forced high", rdy_n, 1);
    chk(stat_q[31] == 1'b1, "R9 overwrite flag", stat_q[31:24], 8'h83);
    ch_en = 4'b0;
    adv(162);
    chk(rdy_n == 1'b1, "R9 still high at end of hold", rdy_n, 1);
    adv(1);
    chk(rdy_n == 1'b0 && rdy_bits == 4'b1010, "R9 hold expired", {rdy_n, rdy_bits}, 5'h0a);
    chk(exp_ch.size() == 0, "R4 no activity when none enabled", exp_ch.size(), 0);

    // Phase B: only ch2, read collision
    expect_res(2, 0); expect_res(2, 2);
    mode(2'd2, 1'b1, 4'b0100);
    chk(rdy_bits == 4'b0 && rdy_n, "R1 mode write clears", {rdy_n, rdy_bits}, 5'h10);
    adv(7);
    chk(rdy_bits == 4'b0100, "R3 single channel", rdy_bits, 4'b0100);
    adv(3);
    rd_busy = 4'b0100;
    adv(6);
    rd_busy = 4'b0;
    chk(data_q[47:32] == 16'h8000, "R10 blocked result dropped", data_q[47:32], 16'h8000);
    chk(rdy_bits == 4'b0, "R10 ready not set", rdy_bits, 0);
    adv(5);
    chk(data_q[47:32] == 16'h8002, "R10 sequence still advanced", data_q[47:32], 16'h8002);
    chk(rdy_bits == 4'b0100, "R3 repeat on itself", rdy_bits, 4'b0100);

    // stop
    mode(2'd0, 1'b0, 4'b0100);
    chk(rdy_bits == 4'b0, "R11 stop clears", rdy_bits, 0);
    adv(20);
    chk(rdy_bits == 4'b0 && exp_ch.size() == 0, "R11 no further results",
        {rdy_bits, 4'(exp_ch.size())}, 0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule